// File: doc/BRIEF.md
# Locality-Aware Coherence Directory Entry

This block is the home-side directory controller for a single cache line, shared by a small fixed set of cores in a full-map arrangement. For every core it holds a mode bit (private or remote) and a small reuse counter. Reads and writes arrive tagged with a core number. The block then decides whether the core receives a whole line for private caching (read-only or read-write), or only a single-word access served by the home L2 slice.

Cores earn private copies by showing reuse. A remote core's directory counter rises with each access it makes, and the core is promoted once the counter reaches a threshold that is set at run time. A core holding a private copy reports how many times it used the line when that copy leaves its cache. The directory then reclassifies the core from that report.

Writes invalidate every core that currently holds a private copy, and the write completes only after all of those cores have acknowledged. Eviction and invalidation acknowledgements arrive on a separate channel that is always accepted.

Top module: `loc_dir_entry`

## Requirements
- R1: After reset, every core is in private mode with a zero counter, `req_ready` is 1, and neither `rsp_valid` nor `inv_valid` is asserted.
- R2: A read from a private-mode core is answered with grant code 0 (read-only line). The core is then recorded as an active private holder, meaning its counter is nonzero.
- R3: An acknowledgement on the ack channel clears that core's counter. It sets the core to private mode if the reported count is greater than or equal to `thresh`, and to remote mode otherwise.
- R4: A read from a remote-mode core whose incremented counter stays below `thresh` is answered with grant code 2 (word read from home L2). The counter keeps the incremented value.
- R5: When a remote core's incremented counter reaches `thresh`, the core is switched to private mode and receives a line: code 0 for a read, code 1 for a write. With `thresh` = 1, the first remote access promotes the core.
- R6: A write from a private-mode core is answered with grant code 1 (read-write line).
- R7: A write from a private-mode core clears the counters of all remote-mode cores.
- R8: A write from a remote-mode core clears every other core's counter and increments its own counter. If the count stays below `thresh`, the answer is grant code 3 (word written into home L2).
- R9: A write sends one invalidation whose bit mask (bit i = core i) holds exactly the active private holders other than the requester. When that set is empty, no invalidation is sent.
- R10: While invalidations are unacknowledged, `req_ready` stays 0 and no response is issued. The response follows only after every invalidated core has acknowledged.
- R11: `rsp_no_alloc` is 1 for grant codes 2 and 3 and 0 for line grants, so the core knows not to install the word.
- R12: A response held by `rsp_ready` = 0 keeps `rsp_valid` and all of its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thresh | input | CNT_W | Reuse threshold for private caching (1 or more) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Requesting core |
| ack_valid | input | 1 | Eviction or invalidation acknowledgement (always accepted) |
| ack_core | input | CW | Acknowledging core |
| ack_count | input | CNT_W | Uses the core counted while it held the line |
| inv_valid | output | 1 | Invalidation command present |
| inv_ready | input | 1 | Network takes the invalidation |
| inv_mask | output | N_CORES | Cores to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_core | output | CW | Core the response is for |
| rsp_grant | output | 2 | 0 read-only line, 1 read-write line, 2 word read, 3 word write |
| rsp_no_alloc | output | 1 | Word-only response; do not allocate |

## Verification
The bench builds the block with four cores and a 4-bit counter. This keeps every invalidation mask small enough to predict by hand, while still allowing multi-core masks such as three simultaneous holders. It runs at a threshold of 3 so that promotion takes several remote reads, and the count before promotion shows whether a write cleared the other cores' counters. It then lowers the threshold to 1 to reach the case where the first remote access promotes the core. Response back-pressure is applied periodically so that held responses occur.

// File: rtl/loc_dir_pkg.sv
// Shared encodings for the locality-aware directory entry.
// Assumes: grant codes are decoded by the requesting core as listed.
package loc_dir_pkg;

    typedef enum logic [1:0] {
        G_LINE_RO = 2'd0,
        G_LINE_RW = 2'd1,
        G_WORD_RD = 2'd2,
        G_WORD_WR = 2'd3
    } grant_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_INV  = 2'd1,
        S_WAIT = 2'd2,
        S_RESP = 2'd3
    } fsm_t;

endpackage

// File: rtl/loc_dir_decide.sv
// Combinational policy for one accepted request: the grant, the cores to
// invalidate, the counters to clear, and the requester's new mode/counter.
// Assumes: cnt of a private core is nonzero only while it holds a copy.
module loc_dir_decide
    import loc_dir_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int CNT_W   = 4,
    parameter int CW      = 3
) (
    input  logic                            is_write,
    input  logic [CW-1:0]                   core,
    input  logic [CNT_W-1:0]                thresh,
    input  logic [N_CORES-1:0]              mode_priv,
    input  logic [N_CORES-1:0][CNT_W-1:0]   cnt,
    output logic [1:0]                      grant,
    output logic                            no_alloc,
    output logic [N_CORES-1:0]              victims,
    output logic [N_CORES-1:0]              clr_mask,
    output logic [CNT_W-1:0]                new_cnt,
    output logic                            new_priv
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [N_CORES-1:0] active;
    logic [N_CORES-1:0] self;
    logic [CNT_W-1:0]   own_cnt;
    logic [CNT_W-1:0]   bumped;
    logic               reached;

    // Active private holders: private mode with a nonzero marker.
    for (genvar gi = 0; gi < N_CORES; gi++) begin : g_active
        assign active[gi] = mode_priv[gi] && (cnt[gi] != '0);
    end

    // Requester one-hot and its saturating counter increment.
    always_comb begin
        self          = '0;
        self[core]    = 1'b1;
        own_cnt       = cnt[core];
        bumped        = (own_cnt == CNT_MAX) ? CNT_MAX : own_cnt + CNT_ONE;
        reached       = (bumped >= thresh);
    end

    // Grant policy and side effects on the other cores.
    always_comb begin
        victims  = is_write ? (active & ~self) : '0;
        if (!is_write)
            clr_mask = '0;
        else if (mode_priv[core])
            clr_mask = ~mode_priv & ~self;
        else
            clr_mask = ~self;

        if (mode_priv[core] || reached) begin
            grant    = is_write ? G_LINE_RW : G_LINE_RO;
            no_alloc = 1'b0;
            new_cnt  = CNT_ONE;
            new_priv = 1'b1;
        end else begin
            grant    = is_write ? G_WORD_WR : G_WORD_RD;
            no_alloc = 1'b1;
            new_cnt  = bumped;
            new_priv = 1'b0;
        end
    end
endmodule

// File: rtl/loc_dir_inv_track.sv
// Tracks which invalidated cores still owe an acknowledgement.
// Assumes: load and an ack never target the same core in one cycle.
module loc_dir_inv_track #(
    parameter int N_CORES = 8,
    parameter int CW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [N_CORES-1:0] load_mask,
    input  logic               ack_valid,
    input  logic [CW-1:0]      ack_core,
    output logic [N_CORES-1:0] pending
);
    // Load the victim set on accept; drop bits as acks arrive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else if (load)
            pending <= load_mask;
        else if (ack_valid)
            pending[ack_core] <= 1'b0;
    end

    // R9: outstanding set only shrinks between loads.
    a_r9_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/loc_dir_entry.sv
// Directory entry for one line: per-core mode and reuse counter, request
// sequencing, invalidation issue and ack collection, response holding.
// Assumes: acks are always accepted; thresh is 1 or more.
module loc_dir_entry
    import loc_dir_pkg::*;
#(
    parameter int N_CORES = 8,
    parameter int CNT_W   = 4,
    localparam int CW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   thresh,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [CW-1:0]      req_core,
    input  logic               ack_valid,
    input  logic [CW-1:0]      ack_core,
    input  logic [CNT_W-1:0]   ack_count,
    output logic               inv_valid,
    input  logic               inv_ready,
    output logic [N_CORES-1:0] inv_mask,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [CW-1:0]      rsp_core,
    output logic [1:0]         rsp_grant,
    output logic               rsp_no_alloc
);
    fsm_t                          state;
    logic [N_CORES-1:0]            mode_priv;
    logic [N_CORES-1:0][CNT_W-1:0] cnt;
    logic [N_CORES-1:0]            pending;
    logic                          accept;

    logic [1:0]         d_grant;
    logic               d_no_alloc;
    logic [N_CORES-1:0] d_victims;
    logic [N_CORES-1:0] d_clr;
    logic [CNT_W-1:0]   d_new_cnt;
    logic               d_new_priv;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign inv_valid = (state == S_INV);
    assign rsp_valid = (state == S_RESP);

    loc_dir_decide #(.N_CORES(N_CORES), .CNT_W(CNT_W), .CW(CW)) u_decide (
        .is_write (req_write),
        .core     (req_core),
        .thresh   (thresh),
        .mode_priv(mode_priv),
        .cnt      (cnt),
        .grant    (d_grant),
        .no_alloc (d_no_alloc),
        .victims  (d_victims),
        .clr_mask (d_clr),
        .new_cnt  (d_new_cnt),
        .new_priv (d_new_priv)
    );

    loc_dir_inv_track #(.N_CORES(N_CORES), .CW(CW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_mask(d_victims),
        .ack_valid(ack_valid),
        .ack_core (ack_core),
        .pending  (pending)
    );

    // Request sequencing: invalidate, wait for acks, then respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE: if (accept) state <= (d_victims != '0) ? S_INV : S_RESP;
                S_INV:  if (inv_ready) state <= S_WAIT;
                S_WAIT: if (pending == '0) state <= S_RESP;
                S_RESP: if (rsp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Capture response fields and invalidation mask at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_core     <= '0;
            rsp_grant    <= '0;
            rsp_no_alloc <= 1'b0;
            inv_mask     <= '0;
        end else if (accept) begin
            rsp_core     <= req_core;
            rsp_grant    <= d_grant;
            rsp_no_alloc <= d_no_alloc;
            inv_mask     <= d_victims;
        end
    end

    // Per-core mode and counter: ack reclassifies, then request overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_priv <= '1;
            cnt       <= '0;
        end else begin
            for (int i = 0; i < N_CORES; i++) begin
                if (ack_valid && (ack_core == CW'(i))) begin
                    cnt[i]       <= '0;
                    mode_priv[i] <= (ack_count >= thresh);
                end
                if (accept) begin
                    if (d_clr[i]) cnt[i] <= '0;
                    if (req_core == CW'(i)) begin
                        cnt[i]       <= d_new_cnt;
                        mode_priv[i] <= d_new_priv;
                    end
                end
            end
        end
    end

    // R10: no new request while acks are outstanding.
    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> !req_ready);
    // R10: a response only after all acks arrived.
    a_r10_resp_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pending == '0));
    // R12: a stalled response stays put.
    a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant)
            && $stable(rsp_core) && $stable(rsp_no_alloc)));
    // R11: no-allocate flag exactly on word grants.
    a_r11_word_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_no_alloc == (rsp_grant == G_WORD_RD || rsp_grant == G_WORD_WR)));
    // R9: an invalidation is never empty and never hits the requester.
    a_r9_inv_mask: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_mask != '0) && !inv_mask[rsp_core]));
endmodule

// File: tb/loc_dir_entry_test.sv
module loc_dir_entry_test;
    localparam int N = 4;
    localparam int CW = 2;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CNT_W-1:0] thresh = 4'd3;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic ack_valid = 1'b0;
    logic [CW-1:0] ack_core = '0;
    logic [CNT_W-1:0] ack_count = '0;
    logic inv_ready = 1'b1;
    logic rsp_ready = 1'b1;
    logic req_ready, inv_valid, rsp_valid, rsp_no_alloc;
    logic [N-1:0] inv_mask;
    logic [CW-1:0] rsp_core;
    logic [1:0] rsp_grant;

    int n_checks = 0, n_fail = 0;
    logic [4:0] exp_q[$];
    string tag_q[$];
    int rr_cnt = 0;
    logic held = 1'b0;
    logic [4:0] held_val = '0;

    always #4 clk = ~clk;

    loc_dir_entry #(.N_CORES(N), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .thresh(thresh),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_core(req_core),
        .ack_valid(ack_valid), .ack_core(ack_core), .ack_count(ack_count),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_mask(inv_mask),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_core(rsp_core),
        .rsp_grant(rsp_grant), .rsp_no_alloc(rsp_no_alloc)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Periodic back-pressure on responses.
    always @(posedge clk) begin
        rr_cnt <= rr_cnt + 1;
        rsp_ready <= ((rr_cnt % 5) != 2);
    end

    // Monitor: pop expected responses, check holding under stall (R12).
    always @(negedge clk) begin
        if (rst_n) begin
            if (held) check(rsp_valid && ({rsp_core, rsp_grant, rsp_no_alloc} == held_val),
                            "R12", "stalled response changed",
                            int'({rsp_valid, rsp_core, rsp_grant, rsp_no_alloc}), int'({1'b1, held_val}));
            held = rsp_valid && !rsp_ready;
            held_val = {rsp_core, rsp_grant, rsp_no_alloc};
            if (rsp_valid && rsp_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected response", int'(held_val), 0);
                end else begin
                    logic [4:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(held_val == e, t, "response {core,grant,no_alloc}", int'(held_val), int'(e));
                end
            end
        end
    end

    // Driver: push the expected response, issue the request, check the invalidation.
    task automatic do_req(input bit wr, input int core, input logic [1:0] g,
                          input logic [N-1:0] mask, input string tag);
        exp_q.push_back({core[CW-1:0], g, g[1]});
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_core = core[CW-1:0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (mask != '0) begin
            check(inv_valid && inv_mask == mask, "R9", "invalidation mask",
                  int'({inv_valid, inv_mask}), int'({1'b1, mask}));
            check(!req_ready, "R10", "ready while acks owed", int'(req_ready), 0);
        end else begin
            check(!inv_valid, "R9", "no invalidation expected", int'(inv_valid), 0);
        end
    endtask

    task automatic do_ack(input int core, input int count);
        @(negedge clk);
        ack_valid = 1'b1; ack_core = core[CW-1:0]; ack_count = count[CNT_W-1:0];
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !inv_valid, "R1", "reset outputs",
              int'({req_ready, rsp_valid, inv_valid}), 4);

        // R1 R2: cores start private, reads get read-only lines.
        do_req(1'b0, 0, 2'd0, 4'b0000, "R2");
        do_req(1'b0, 1, 2'd0, 4'b0000, "R2");
        // R6: private write invalidates holders 0 and 1.
        do_req(1'b1, 2, 2'd1, 4'b0011, "R6");
        do_ack(0, 4);
        check(!req_ready && !rsp_valid, "R10", "busy between acks",
              int'({req_ready, rsp_valid}), 0);
        do_ack(1, 1);
        drain();
        // R3: core 0 stays private, core 1 turns remote.
        do_req(1'b0, 0, 2'd0, 4'b0000, "R3");
        do_req(1'b0, 1, 2'd2, 4'b0000, "R4");
        do_req(1'b0, 1, 2'd2, 4'b0000, "R4");
        do_req(1'b0, 1, 2'd0, 4'b0000, "R5");
        // R8: remote write below threshold.
        do_ack(3, 0);
        do_req(1'b0, 3, 2'd2, 4'b0000, "R3");
        do_req(1'b1, 3, 2'd3, 4'b0111, "R8");
        do_ack(0, 4);
        do_ack(1, 0);
        do_ack(2, 7);
        drain();
        // R8: other counters cleared; requester reaches threshold on write (R5).
        do_req(1'b0, 1, 2'd2, 4'b0000, "R4");
        do_req(1'b1, 3, 2'd1, 4'b0000, "R5");
        do_req(1'b0, 1, 2'd2, 4'b0000, "R8");
        do_req(1'b0, 1, 2'd2, 4'b0000, "R8");
        do_req(1'b0, 1, 2'd0, 4'b0000, "R5");
        // R7: private write clears a remote core's progress.
        do_ack(2, 0);
        do_req(1'b0, 2, 2'd2, 4'b0000, "R4");
        do_req(1'b0, 2, 2'd2, 4'b0000, "R4");
        do_req(1'b1, 0, 2'd1, 4'b1010, "R6");
        do_ack(1, 9);
        do_ack(3, 9);
        drain();
        do_req(1'b0, 2, 2'd2, 4'b0000, "R7");
        do_req(1'b0, 2, 2'd2, 4'b0000, "R7");
        do_req(1'b0, 2, 2'd0, 4'b0000, "R7");
        // R5 boundary: threshold 1 promotes on first remote access.
        thresh = 4'd1;
        do_ack(2, 0);
        do_req(1'b0, 2, 2'd0, 4'b0000, "R5");
        drain();
        check(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule